// File: doc/BRIEF.md
# Sticky Interrupt Status Registers with Read-Clear

This block holds the latched error state behind a hardware-monitor interrupt line. Two 8-bit status registers collect one bit per monitored condition: voltage or fan quantities out of limits, temperature window events, and a thermal pin held low by outside circuitry. The limit comparators sit elsewhere and present one flag per bit, together with a one-cycle strobe that marks the end of each conversion round. Flags are sampled only on that strobe. Once set, a bit stays set until software reads its register, even if the condition has gone away in the meantime.

A read strobe with a register selector returns the register contents on the same cycle. A status read then clears that register on the following edge. A mirror read returns the same value and leaves it untouched. A bit that is set again by the conversion strobe in the same cycle as its clearing read stays set. Each bit is gated by a mask input, and the OR of all unmasked bits forms a summary level for the interrupt output combiner.

Top module: `isr_status_regs`

## Requirements
- R1: When `conv_done` is high at a rising edge, each `err_flags` bit that is 1 sets the matching status bit. Flag bits 7..0 map to register 0 and bits 15..8 to register 1. No status bit goes from 0 to 1 on an edge without `conv_done`.
- R2: A set status bit stays set while neither a status read of its register nor reset occurs, whatever `err_flags` does.
- R3: With `rd_stb` high and `rd_sel` = 0 (status 0) or 1 (status 1), `rd_data` shows that register's current contents in the same cycle.
- R4: A status read clears the addressed register at the next rising edge and leaves the other register unchanged. A second status read before the next `conv_done` returns 0.
- R5: A status bit feeds `irq_summary` only when its `mask` bit is 0. `irq_summary` is 1 exactly when some status bit is 1 with mask 0.
- R6: Status bit 12 (register 1, bit 4) is the external thermal-pull bit. At `conv_done` it is set only when `therm_pin_n` is 0 and `therm_drv` is 0. `err_flags[12]` has no effect.
- R7: If the external pull persists after a read clears bit 12, bit 12 is set again at the next `conv_done`.
- R8: With `rd_sel` = 2 (mirror 0) or 3 (mirror 1), `rd_data` returns the same value as the matching status register, and the read clears nothing.
- R9: If `conv_done` sets a bit in the same cycle that a status read clears its register, that bit is 1 afterwards. The read returns the value from before the edge, and the register's other bits are cleared.
- R10: After reset, both registers are 0 and `irq_summary` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe at the end of a conversion round |
| err_flags | input | 16 | Per-bit error flags from the limit comparators |
| therm_pin_n | input | 1 | Sensed thermal pin level, 0 = low |
| therm_drv | input | 1 | 1 while this chip itself drives the thermal pin low |
| mask | input | 16 | Per-bit interrupt mask, 1 = blocked |
| rd_stb | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read selector: bit 1 = mirror, bit 0 = register index |
| rd_data | output | 8 | Contents of the selected register |
| irq_summary | output | 1 | OR of unmasked status bits |

## Verification
Two functions can fall in the same cycle: the set from the conversion strobe and the clear from a status read. The bench provokes this by raising `conv_done` and a status read of the same register on one edge. It sweeps flag patterns that overlap and do not overlap the bits already held. It judges the outcome through mirror reads afterwards: bits flagged on that edge must survive, and bits held only from before must be gone. It also checks that the read itself returned the value from before the edge.

// File: rtl/isr_pkg.sv
package isr_pkg;

  // Next value of one status register: clear from a read, then set from a
  // conversion; a set on the same edge therefore survives the clear.
  function automatic logic [63:0] upd_bits(input logic [63:0] cur,
                                           input logic [63:0] clr,
                                           input logic [63:0] set);
    return (cur & ~clr) | set;
  endfunction

  // The pin counts as pulled from outside only when low and not driven by us.
  function automatic logic ext_pull(input logic pin_n, input logic drv);
    return ~pin_n & ~drv;
  endfunction

  // Does a read strobe target status register `bank` (not a mirror)?
  function automatic logic hits_status(input logic stb, input logic mirror,
                                       input int unsigned idx,
                                       input int unsigned bank);
    return stb && !mirror && (idx == bank);
  endfunction

endpackage

// File: rtl/isr_therm_sense.sv
module isr_therm_sense (
  input  logic therm_pin_n,
  input  logic therm_drv,
  output logic ext_pull
);
  import isr_pkg::*;

  always_comb ext_pull = isr_pkg::ext_pull(therm_pin_n, therm_drv);

endmodule

// File: rtl/isr_set_build.sv
module isr_set_build #(
  parameter int NB        = 16,
  parameter int THERM_IDX = 12
) (
  input  logic          conv_done,
  input  logic [NB-1:0] err_flags,
  input  logic          ext_pull,
  output logic [NB-1:0] set_vec
);

  logic [NB-1:0] raw;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bit
      if (i == THERM_IDX) begin : g_therm
        assign raw[i] = ext_pull;
      end else begin : g_flag
        assign raw[i] = err_flags[i];
      end
    end
  endgenerate

  assign set_vec = conv_done ? raw : '0;

endmodule

// File: rtl/isr_bank.sv
module isr_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic         clr,
  output logic [W-1:0] q
);
  import isr_pkg::*;

  logic [63:0] nxt_wide;
  logic [W-1:0] nxt;

  always_comb begin
    nxt_wide = upd_bits(64'(q), {64{clr}}, 64'(set_bits));
    nxt      = nxt_wide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/isr_rd_mux.sv
module isr_rd_mux #(
  parameter int W     = 8,
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [W*N-1:0] regs,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]   data
);

  always_comb begin
    data = '0;
    for (int b = 0; b < N; b++) begin
      if (int'(idx) == b) data = regs[b*W +: W];
    end
  end

endmodule

// File: rtl/isr_status_regs.sv
module isr_status_regs #(
  parameter int REG_W     = 8,
  parameter int N_REGS    = 2,
  parameter int THERM_IDX = 12,
  localparam int NB       = REG_W * N_REGS,
  localparam int IDX_W    = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int SEL_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [NB-1:0]    err_flags,
  input  logic             therm_pin_n,
  input  logic             therm_drv,
  input  logic [NB-1:0]    mask,
  input  logic             rd_stb,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_summary
);
  import isr_pkg::*;

  // Named internal events, observed by the bound checker.
  logic             ext_pull;
  logic [NB-1:0]    set_vec;
  logic [N_REGS-1:0] clr_bank;
  logic [NB-1:0]    stat_q;
  logic             rd_mirror;
  logic [IDX_W-1:0] rd_idx;

  assign rd_mirror = rd_sel[SEL_W-1];
  assign rd_idx    = rd_sel[IDX_W-1:0];

  isr_therm_sense u_therm (
    .therm_pin_n (therm_pin_n),
    .therm_drv   (therm_drv),
    .ext_pull    (ext_pull)
  );

  isr_set_build #(.NB(NB), .THERM_IDX(THERM_IDX)) u_set (
    .conv_done (conv_done),
    .err_flags (err_flags),
    .ext_pull  (ext_pull),
    .set_vec   (set_vec)
  );

  generate
    for (genvar b = 0; b < N_REGS; b++) begin : g_bank
      assign clr_bank[b] = hits_status(rd_stb, rd_mirror, int'(rd_idx), b);

      isr_bank #(.W(REG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_vec[b*REG_W +: REG_W]),
        .clr      (clr_bank[b]),
        .q        (stat_q[b*REG_W +: REG_W])
      );
    end
  endgenerate

  // Mirror and status views share one copy of the bits.
  isr_rd_mux #(.W(REG_W), .N(N_REGS), .IDX_W(IDX_W)) u_mux (
    .regs (stat_q),
    .idx  (rd_idx),
    .data (rd_data)
  );

  assign irq_summary = |(stat_q & ~mask);

endmodule

// File: rtl/isr_status_chk.sv
module isr_status_chk #(
  parameter int REG_W     = 8,
  parameter int N_REGS    = 2,
  parameter int THERM_IDX = 12,
  localparam int NB       = REG_W * N_REGS,
  localparam int IDX_W    = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int SEL_W    = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic [NB-1:0]    err_flags,
  input logic             therm_pin_n,
  input logic             therm_drv,
  input logic [NB-1:0]    mask,
  input logic             rd_stb,
  input logic [SEL_W-1:0] rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_summary,
  input logic [NB-1:0]    stat_q
);

  localparam logic [NB-1:0] THERM_ONE = NB'(1) << THERM_IDX;

  logic [NB-1:0] plain_flags;
  assign plain_flags = err_flags & ~THERM_ONE;

  // R1: flagged bits are set after a conversion strobe
  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ((stat_q & $past(plain_flags)) == $past(plain_flags)));

  // R1: no new bit without a conversion strobe
  p_noset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> ((stat_q & ~$past(stat_q)) == '0));

  // R2: bits hold while nothing sets or clears
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !rd_stb) |=> $stable(stat_q));

  // R3: status read shows register 0 contents
  p_rddata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_sel == '0) |-> (rd_data == stat_q[REG_W-1:0]));

  // R4: status read clears register 0
  p_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_sel == '0 && !conv_done) |=> (stat_q[REG_W-1:0] == '0));

  // R5: all bits masked or clear means no summary
  p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~mask) == '0) |-> !irq_summary);

  // R5: an unmasked set bit raises the summary
  p_mask_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~mask) != '0) |-> irq_summary);

  // R6: own drive hides the pin
  p_therm_hide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && therm_drv && !stat_q[THERM_IDX]) |=> !stat_q[THERM_IDX]);

  // R7: external pull sets the thermal bit at each conversion
  p_therm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !therm_pin_n && !therm_drv) |=> stat_q[THERM_IDX]);

  // R8: mirror reads change nothing
  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_sel[SEL_W-1] && !conv_done) |=> $stable(stat_q));

  // R9: set beats clear on the same edge
  p_setwins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_stb && rd_sel == '0 && plain_flags[0]) |=> stat_q[0]);

endmodule

bind isr_status_regs isr_status_chk #(
  .REG_W     (REG_W),
  .N_REGS    (N_REGS),
  .THERM_IDX (THERM_IDX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_done   (conv_done),
  .err_flags   (err_flags),
  .therm_pin_n (therm_pin_n),
  .therm_drv   (therm_drv),
  .mask        (mask),
  .rd_stb      (rd_stb),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .irq_summary (irq_summary),
  .stat_q      (stat_q)
);

// File: tb/sim_isr_status_regs.sv
module sim_isr_status_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] err_flags = '0;
  logic        therm_pin_n = 1'b1;
  logic        therm_drv = 1'b0;
  logic [15:0] mask = '0;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        irq_summary;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_q = '0;   // bench model of the two registers

  always #5 clk = ~clk;

  isr_status_regs u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .err_flags(err_flags),
    .therm_pin_n(therm_pin_n), .therm_drv(therm_drv), .mask(mask),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_summary(irq_summary)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] expv,
                     input string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One clock: drive at negedge, check combinational outputs, clock, update model.
  task automatic cyc(input logic cv, input logic [15:0] fl, input logic pin_n,
                     input logic drv, input logic rd, input logic [1:0] sel,
                     input string req);
    logic [15:0] setv;
    logic [15:0] clrv;
    @(negedge clk);
    conv_done = cv; err_flags = fl; therm_pin_n = pin_n; therm_drv = drv;
    rd_stb = rd; rd_sel = sel;
    #1;
    if (rd) chk({8'h0, rd_data}, {8'h0, sel[0] ? exp_q[15:8] : exp_q[7:0]}, req);
    chk({15'h0, irq_summary}, {15'h0, |(exp_q & ~mask)}, "R5");
    setv = '0;
    if (cv) begin
      setv = fl;
      setv[12] = !pin_n && !drv;
    end
    clrv = '0;
    if (rd && !sel[1]) clrv = sel[0] ? 16'hFF00 : 16'h00FF;
    @(posedge clk);
    exp_q = (exp_q & ~clrv) | setv;
  endtask

  task automatic idle();
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R2");
  endtask

  task automatic peek(input string req);
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd2, req);
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd3, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    total++; bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R10: reset state
    #1;
    chk({15'h0, irq_summary}, 16'h0, "R10");
    @(negedge clk); rst_n = 1'b1;
    peek("R10");

    // R1 R3 R4 R8: every pattern in each register
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < 256; v++) begin
        logic [15:0] fl;
        fl = b ? {8'(v), 8'h00} : {8'h00, 8'(v)};
        fl[12] = 1'b0;
        cyc(1'b1, fl, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
        peek("R8");
        cyc(1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 2'(b), "R3");
        cyc(1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 2'(b), "R4");
        peek("R4");
      end
    end

    // R2: sticky after the condition goes away, flags wiggle without strobe
    cyc(1'b1, 16'hA5C3, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
    for (int k = 0; k < 8; k++) cyc(1'b0, 16'(k * 16'h1111), 1'b1, 1'b0, 1'b0, 2'd0, "R2");
    peek("R2");
    chk(exp_q, 16'hA5C3 & ~16'h1000, "R2");

    // R4: reading one register leaves the other alone
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd1, "R3");
    peek("R4");
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd0, "R3");
    peek("R4");

    // R5: mask sweep over held patterns
    cyc(1'b1, 16'h0081, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
    for (int m = 0; m < 256; m++) begin
      mask = {8'hFF, 8'(m)};
      idle();
    end
    cyc(1'b1, 16'h8000, 1'b1, 1'b0, 1'b1, 2'd0, "R3");
    for (int m = 0; m < 256; m++) begin
      mask = {8'(m), 8'hFF};
      idle();
    end
    mask = '0;
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd1, "R3");

    // R6: thermal bit over all pin/drive combinations, flag bit ignored
    for (int c = 0; c < 4; c++) begin
      cyc(1'b1, 16'h1000, c[0], c[1], 1'b0, 2'd0, "R6");
      peek("R6");
      cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd1, "R6");
    end

    // R7: pull persists: read clears, next conversion sets again
    cyc(1'b1, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
    cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 2'd1, "R7");
    peek("R7");
    chk(exp_q, 16'h0000, "R7");
    cyc(1'b1, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
    peek("R7");
    chk(exp_q, 16'h1000, "R7");
    cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd1, "R4");

    // R9: set and clear on the same edge, overlapping and disjoint patterns
    for (int v = 0; v < 256; v += 17) begin
      cyc(1'b1, 16'h00F0, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
      cyc(1'b1, {8'h00, 8'(v)}, 1'b1, 1'b0, 1'b1, 2'd0, "R9");
      peek("R9");
      chk(exp_q, {8'h00, 8'(v)}, "R9");
      cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 2'd0, "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule